// File: doc/BRIEF.md
# Streaming 9/7 Lifting Wavelet Analysis Unit

This block computes a one-level, one-dimensional forward 9/7 biorthogonal wavelet transform on a stream of signed samples. The samples arrive one per cycle at most, framed into rows of a fixed length. Each row is split into even and odd phases. The pairs then pass through two predict steps and two update steps in cascade. A final pair of constant scalings turns the result into one low-pass and one high-pass coefficient per input pair. A row of `ROW_LEN` samples gives `ROW_LEN/2` output pairs, in order. Each output pair is flagged by a single-cycle valid strobe, and the first and last pairs of a row are marked.

Every constant product comes from a table-driven constant multiplier. The variable operand is cut into 4-bit slices, and each slice indexes a 16-entry table of precomputed coefficient×slice values. The top slice is read as signed. The shifted partial products are summed and then rounded. Registers stand only between whole steps, so the longest path in any step is one adder, one multiplier and one adder.

Missing neighbours at both ends of a row are filled by mirror extension. A predict step that needs the next even value beyond the row end reuses the last one. An update step that needs the odd value before the row start reuses the first one.

Top module: `dwt97_lift`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `in_ready` are low after that edge.
- R2: Once out of reset, `in_ready` stays high. A sample is taken on every edge with `in_valid` high. Sample k of a row (k counted from 0) is even when k is even, and the pair (x[2n], x[2n+1]) is pair n.
- R3: The predict steps compute d[n] = o[n] + r(C·(e[n]+e[n+1])) with C = −102/64 for the first step and C = 57/64 for the second step. The rounding is r(p) = floor((p + 32)/64) on the integer product.
- R4: The update steps compute s[n] = e[n] + r(C·(d[n−1]+d[n])) with C = −3/64 for the first step and C = 28/64 for the second step.
- R5: The outputs are out_low = r(74·s) and out_high = r(56·d), taken from the second update and second predict results.
- R6: At the row end, the even neighbour after the last pair is the last even value itself (e[M] = e[M−1], where M = ROW_LEN/2).
- R7: At the row start, the odd neighbour before the first pair is the first odd value itself (d[−1] = d[0]).
- R8: With samples supplied on consecutive edges, the first output pair of a row is visible 10 clock edges after the edge that took the row's first sample.
- R9: Cycles with `in_valid` low are ignored, whatever value `in_data` holds. Results do not depend on the spacing of the samples.
- R10: Every 11-bit signed input, including −1024 and +1023, gives exact results in `DW`-bit signed outputs. This works because the signed top slice makes negative operands multiply correctly.
- R11: `out_valid` is high for exactly one cycle per output pair. `out_first` is 1 only for pair 0 of a row, `out_last` is 1 only for pair M−1, and no pair is emitted before its input pair is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present |
| in_data | input | IN_W | Signed input sample |
| in_ready | output | 1 | Block accepts samples |
| out_valid | output | 1 | Output pair strobe |
| out_low | output | DW | Signed low-pass coefficient |
| out_high | output | DW | Signed high-pass coefficient |
| out_first | output | 1 | Pair is first of its row |
| out_last | output | 1 | Pair is last of its row |

## Verification
The hardest situation to reach is where the mirror extension at a row end meets the next row's first pairs in the two look-ahead stages. Here the end-of-row flush cycles must not collide with new tokens. The bench reaches it by sending many rows back to back with no idle cycles. One sweep places a single nonzero sample at each of the sixteen positions of a row, in both signs, so each boundary term is isolated. A row sent with irregular idle gaps and garbage data shows that spacing has no effect.

// File: rtl/dwt97_pkg.sv
`timescale 1ns/1ps
// Shared constants for the 9/7 lifting unit: signed Q1.6 step coefficients,
// rounding precision and the fixed first-output latency.
package dwt97_pkg;
    localparam int COEF_W = 8;
    localparam int FRAC   = 6;
    localparam logic signed [COEF_W-1:0] K_PRED1 = -8'sd102; // about -1.586
    localparam logic signed [COEF_W-1:0] K_UPD1  = -8'sd3;   // about -0.053
    localparam logic signed [COEF_W-1:0] K_PRED2 = 8'sd57;   // about  0.883
    localparam logic signed [COEF_W-1:0] K_UPD2  = 8'sd28;   // about  0.444
    localparam logic signed [COEF_W-1:0] K_SC_LO = 8'sd74;   // about  1.149
    localparam logic signed [COEF_W-1:0] K_SC_HI = 8'sd56;   // about  1/1.149
    localparam int LATENCY = 10;  // edges, first sample taken to first pair visible
endpackage

// File: rtl/dwt97_kcm.sv
`timescale 1ns/1ps
// Table-driven constant multiplier with round-to-nearest.
// Splits the signed operand into 4-bit slices. Each slice indexes a 16-entry
// table of COEF*slice, and the top slice is signed. Partial products are
// shifted, summed, then rounded by FRAC bits. Purely combinational.
module dwt97_kcm #(
    parameter int XW = 17,
    parameter int OW = 16,
    parameter int CW = 8,
    parameter int FRAC = 6,
    parameter logic signed [CW-1:0] COEF = '0
) (
    input  logic signed [XW-1:0] x,
    output logic signed [OW-1:0] y
);
    localparam int NSL  = (XW + 3) / 4;
    localparam int EW   = NSL * 4;
    localparam int PW   = EW + CW;
    localparam int HALF = 1 << (FRAC - 1);

    function automatic logic signed [PW-1:0] rom_entry(input int idx, input bit top);
        int v;
        v = (top && idx >= 8) ? idx - 16 : idx;
        return PW'(int'(COEF) * v);
    endfunction

    logic signed [EW-1:0] xe;
    logic signed [PW-1:0] part [NSL];
    logic signed [PW-1:0] acc;
    logic signed [PW-1:0] biased;

    assign xe = EW'(x);

    for (genvar i = 0; i < NSL; i++) begin : g_slice
        localparam bit TOP = (i == NSL - 1);
        logic signed [PW-1:0] rom [16];
        // Fill this slice's product table
        always_comb begin
            for (int k = 0; k < 16; k++) rom[k] = rom_entry(k, TOP);
        end
        assign part[i] = rom[xe[4*i +: 4]] <<< (4 * i);
    end

    // Sum shifted partial products
    always_comb begin
        acc = '0;
        for (int i = 0; i < NSL; i++) acc = acc + part[i];
    end

    assign biased = acc + PW'(HALF);
    assign y = OW'(biased >>> FRAC);
endmodule

// File: rtl/dwt97_predict.sv
`timescale 1ns/1ps
// Predict lifting step: d[n] += C*(s[n] + s[n+1]).
// Holds one pair to get the look-ahead even value. At the row's last pair it
// emits the held pair, then on the next cycle flushes the last pair with
// s[M] = s[M-1]. Assumes input tokens are at least two cycles apart.
module dwt97_predict #(
    parameter int DW = 16,
    parameter logic signed [7:0] COEF = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic signed [DW-1:0] in_s,
    input  logic signed [DW-1:0] in_d,
    output logic                 out_vld,
    output logic                 out_first,
    output logic                 out_last,
    output logic signed [DW-1:0] out_s,
    output logic signed [DW-1:0] out_d
);
    logic signed [DW-1:0] h_s, h_d, nxt_s, prod;
    logic signed [DW:0]   psum;
    logic                 h_first, flush, emit;

    assign nxt_s = flush ? h_s : in_s;
    assign psum  = (DW+1)'(h_s) + (DW+1)'(nxt_s);
    assign emit  = flush || (in_vld && !in_first);

    dwt97_kcm #(.XW(DW+1), .OW(DW), .CW(8), .FRAC(dwt97_pkg::FRAC), .COEF(COEF))
        i_mul (.x(psum), .y(prod));

    // Control state: emit strobe and pending flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            flush   <= 1'b0;
        end else begin
            out_vld <= emit;
            flush   <= in_vld && in_last;
        end
    end

    // Data path: held pair and stage result
    always_ff @(posedge clk) begin
        if (emit) begin
            out_s     <= h_s;
            out_d     <= h_d + prod;
            out_first <= h_first;
            out_last  <= flush;
        end
        if (in_vld) begin
            h_s     <= in_s;
            h_d     <= in_d;
            h_first <= in_first;
        end
    end
endmodule

// File: rtl/dwt97_update.sv
`timescale 1ns/1ps
// Update lifting step: s[n] += C*(d[n-1] + d[n]), using d[-1] = d[0] at the
// row start. One register stage, with no look-ahead.
module dwt97_update #(
    parameter int DW = 16,
    parameter logic signed [7:0] COEF = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic signed [DW-1:0] in_s,
    input  logic signed [DW-1:0] in_d,
    output logic                 out_vld,
    output logic                 out_first,
    output logic                 out_last,
    output logic signed [DW-1:0] out_s,
    output logic signed [DW-1:0] out_d
);
    logic signed [DW-1:0] p_d, prv, prod;
    logic signed [DW:0]   psum;

    assign prv  = in_first ? in_d : p_d;
    assign psum = (DW+1)'(prv) + (DW+1)'(in_d);

    dwt97_kcm #(.XW(DW+1), .OW(DW), .CW(8), .FRAC(dwt97_pkg::FRAC), .COEF(COEF))
        i_mul (.x(psum), .y(prod));

    // Valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
    end

    // Stage result and previous odd value
    always_ff @(posedge clk) begin
        if (in_vld) begin
            out_s     <= in_s + prod;
            out_d     <= in_d;
            out_first <= in_first;
            out_last  <= in_last;
            p_d       <= in_d;
        end
    end
endmodule

// File: rtl/dwt97_lift.sv
`timescale 1ns/1ps
// Top of the 9/7 lifting unit. It splits the sample stream into even/odd
// pairs, cascades predict/update/predict/update, and scales the results.
// Assumes ROW_LEN is even and at least 6, and at most one sample per cycle.
module dwt97_lift #(
    parameter int IN_W    = 11,
    parameter int DW      = 16,
    parameter int ROW_LEN = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [IN_W-1:0]      in_data,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic [DW-1:0]        out_low,
    output logic [DW-1:0]        out_high,
    output logic                 out_first,
    output logic                 out_last
);
    import dwt97_pkg::*;
    localparam int PAIRS = ROW_LEN / 2;
    localparam int CNT_W = $clog2(ROW_LEN);

    typedef struct packed {
        logic                 vld;
        logic                 first;
        logic                 last;
        logic signed [DW-1:0] s;
        logic signed [DW-1:0] d;
    } tok_t;

    logic [CNT_W-1:0]     col, pidx;
    logic signed [DW-1:0] in_x, ev;
    logic                 take;
    tok_t                 t_pair, t_p1, t_u1, t_p2, t_u2;
    logic signed [DW-1:0] lo_n, hi_n;

    assign take = in_valid && in_ready;
    assign in_x = DW'($signed(in_data));
    assign pidx = col >> 1;

    // Ready flag and position within the row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ready <= 1'b0;
            col      <= '0;
            t_pair.vld <= 1'b0;
        end else begin
            in_ready   <= 1'b1;
            t_pair.vld <= take && col[0];
            if (take) col <= (col == CNT_W'(ROW_LEN - 1)) ? '0 : col + 1'b1;
        end
    end

    // Phase split: keep the even sample and form the pair on the odd one
    always_ff @(posedge clk) begin
        if (take && !col[0]) ev <= in_x;
        if (take && col[0]) begin
            t_pair.s     <= ev;
            t_pair.d     <= in_x;
            t_pair.first <= (pidx == '0);
            t_pair.last  <= (pidx == CNT_W'(PAIRS - 1));
        end
    end

    dwt97_predict #(.DW(DW), .COEF(K_PRED1)) i_p1 (
        .clk, .rst_n, .in_vld(t_pair.vld), .in_first(t_pair.first), .in_last(t_pair.last),
        .in_s(t_pair.s), .in_d(t_pair.d), .out_vld(t_p1.vld), .out_first(t_p1.first),
        .out_last(t_p1.last), .out_s(t_p1.s), .out_d(t_p1.d));

    dwt97_update #(.DW(DW), .COEF(K_UPD1)) i_u1 (
        .clk, .rst_n, .in_vld(t_p1.vld), .in_first(t_p1.first), .in_last(t_p1.last),
        .in_s(t_p1.s), .in_d(t_p1.d), .out_vld(t_u1.vld), .out_first(t_u1.first),
        .out_last(t_u1.last), .out_s(t_u1.s), .out_d(t_u1.d));

    dwt97_predict #(.DW(DW), .COEF(K_PRED2)) i_p2 (
        .clk, .rst_n, .in_vld(t_u1.vld), .in_first(t_u1.first), .in_last(t_u1.last),
        .in_s(t_u1.s), .in_d(t_u1.d), .out_vld(t_p2.vld), .out_first(t_p2.first),
        .out_last(t_p2.last), .out_s(t_p2.s), .out_d(t_p2.d));

    dwt97_update #(.DW(DW), .COEF(K_UPD2)) i_u2 (
        .clk, .rst_n, .in_vld(t_p2.vld), .in_first(t_p2.first), .in_last(t_p2.last),
        .in_s(t_p2.s), .in_d(t_p2.d), .out_vld(t_u2.vld), .out_first(t_u2.first),
        .out_last(t_u2.last), .out_s(t_u2.s), .out_d(t_u2.d));

    dwt97_kcm #(.XW(DW), .OW(DW), .CW(COEF_W), .FRAC(FRAC), .COEF(K_SC_LO))
        i_sc_lo (.x(t_u2.s), .y(lo_n));
    dwt97_kcm #(.XW(DW), .OW(DW), .CW(COEF_W), .FRAC(FRAC), .COEF(K_SC_HI))
        i_sc_hi (.x(t_u2.d), .y(hi_n));

    // Output strobe
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= t_u2.vld;
    end

    // Scaled output pair and row markers
    always_ff @(posedge clk) begin
        if (t_u2.vld) begin
            out_low   <= lo_n;
            out_high  <= hi_n;
            out_first <= t_u2.first;
            out_last  <= t_u2.last;
        end
    end
endmodule

// File: rtl/dwt97_lift_chk.sv
`timescale 1ns/1ps
// Property checker for dwt97_lift, attached by bind. Uses port-level
// counters for latency and ordering.
module dwt97_lift_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic [DW-1:0] out_low,
    input logic [DW-1:0] out_high
);
    localparam int LIM = 1 << (DW - 2);
    logic [31:0] n_acc, n_out, since;
    logic        seen;

    // Count accepted samples, emitted pairs and cycles since the first sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_acc <= '0;
            n_out <= '0;
            since <= '0;
            seen  <= 1'b0;
        end else begin
            if (in_valid && in_ready) n_acc <= n_acc + 1;
            if (out_valid) n_out <= n_out + 1;
            if (!seen && in_valid && in_ready) begin
                seen  <= 1'b1;
                since <= '0;
            end else if (seen && since != '1) begin
                since <= since + 1;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && !in_ready));
    // R2
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);
    // R8
    first_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seen && since >= 32'(dwt97_pkg::LATENCY)));
    // R11
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((n_acc >> 1) > n_out));
    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_low) < LIM && $signed(out_low) > -LIM &&
                       $signed(out_high) < LIM && $signed(out_high) > -LIM));
endmodule

bind dwt97_lift dwt97_lift_chk #(.DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_low(out_low), .out_high(out_high));

// File: tb/test_dwt97_lift.sv
`timescale 1ns/1ps
// Self-checking bench: rows of samples against an integer lifting model.
module test_dwt97_lift;
    localparam int IN_W = 11, DW = 16, ROW = 16, M = ROW / 2;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic [IN_W-1:0] in_data = '0;
    logic in_ready, out_valid, out_first, out_last;
    logic [DW-1:0] out_low, out_high;

    int n_chk = 0, n_fail = 0, cyc = 0, first_take = -1, first_out = -1, n_pairs = 0;
    int row_buf [ROW];
    int q_lo[$], q_hi[$], q_idx[$];
    string q_tag[$];
    string tag = "R3";
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    dwt97_lift #(.IN_W(IN_W), .DW(DW), .ROW_LEN(ROW)) i_dwt97_lift (
        .clk, .rst_n, .in_valid, .in_data, .in_ready, .out_valid,
        .out_low, .out_high, .out_first, .out_last);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int c, input int v);
        return (c * v + 32) >>> 6;
    endfunction

    // Spec model of one row; queue expected pairs
    task automatic model_row();
        int e[M], o[M], d1[M], s1[M], d2[M], s2[M];
        for (int n = 0; n < M; n++) begin
            e[n] = row_buf[2*n]; o[n] = row_buf[2*n+1];
        end
        for (int n = 0; n < M; n++) d1[n] = o[n] + rnd(-102, e[n] + e[(n < M-1) ? n+1 : M-1]);
        for (int n = 0; n < M; n++) s1[n] = e[n] + rnd(-3, d1[(n > 0) ? n-1 : 0] + d1[n]);
        for (int n = 0; n < M; n++) d2[n] = d1[n] + rnd(57, s1[n] + s1[(n < M-1) ? n+1 : M-1]);
        for (int n = 0; n < M; n++) s2[n] = s1[n] + rnd(28, d2[(n > 0) ? n-1 : 0] + d2[n]);
        for (int n = 0; n < M; n++) begin
            q_lo.push_back(rnd(74, s2[n]));
            q_hi.push_back(rnd(56, d2[n]));
            q_idx.push_back(n);
            q_tag.push_back(tag);
        end
    endtask

    // Drive one row; gaps inserts idle cycles carrying garbage data
    task automatic send_row(input bit gaps);
        model_row();
        for (int i = 0; i < ROW; i++) begin
            if (gaps) begin
                for (int g = 0; g < (i % 3); g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_data  = IN_W'(12'h5a5 + i);
                end
            end
            @(negedge clk);
            if (first_take < 0) first_take = cyc + 1;
            in_valid = 1'b1;
            in_data  = IN_W'(row_buf[i]);
        end
    endtask

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            int lo, hi, idx;
            string t;
            if (first_out < 0) first_out = cyc;
            n_pairs++;
            if (q_lo.size() == 0) begin
                chk(1'b0, "R11", n_pairs, 0);
            end else begin
                lo = q_lo.pop_front(); hi = q_hi.pop_front();
                idx = q_idx.pop_front(); t = q_tag.pop_front();
                chk(int'($signed(out_low)) == lo, t, int'($signed(out_low)), lo);
                chk(int'($signed(out_high)) == hi, t, int'($signed(out_high)), hi);
                chk(out_first == (idx == 0), "R11", int'(out_first), int'(idx == 0));
                chk(out_last == (idx == M-1), "R11", int'(out_last), int'(idx == M-1));
            end
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        chk(!out_valid, "R1", int'(out_valid), 0);
        chk(!in_ready, "R1", int'(in_ready), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready, "R2", int'(in_ready), 1);

        // Ramp row, back to back: main arithmetic (R3, R4, R5) and latency (R8)
        tag = "R3";
        for (int i = 0; i < ROW; i++) row_buf[i] = i * 64 - 512;
        send_row(1'b0);
        // DC row stresses the scaling pair
        tag = "R5";
        for (int i = 0; i < ROW; i++) row_buf[i] = 700;
        send_row(1'b0);
        // Impulse sweep over every position, both signs (R6 end, R7 start, R4 interior)
        for (int sg = 0; sg < 2; sg++) begin
            for (int p = 0; p < ROW; p++) begin
                tag = (p < 4) ? "R7" : (p >= ROW - 4) ? "R6" : "R4";
                for (int i = 0; i < ROW; i++) row_buf[i] = 0;
                row_buf[p] = sg ? -1000 : 1000;
                send_row(1'b0);
            end
        end
        // Full-scale signed extremes (R10)
        tag = "R10";
        for (int i = 0; i < ROW; i++) row_buf[i] = (i % 2) ? -1024 : 1023;
        send_row(1'b0);
        for (int i = 0; i < ROW; i++) row_buf[i] = (i % 2) ? 1023 : -1024;
        send_row(1'b0);
        // Pseudo-random rows
        tag = "R4";
        lf = 16'hace1;
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < ROW; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                row_buf[i] = int'($signed(lf[10:0]));
            end
            send_row(1'b0);
        end
        // Irregular idle gaps with garbage data (R9)
        tag = "R9";
        for (int i = 0; i < ROW; i++) row_buf[i] = (i * 37) % 300 - 150;
        send_row(1'b1);
        @(negedge clk); in_valid = 1'b0;
        repeat (40) @(negedge clk);

        // R8: first pair latency
        chk(first_out - first_take == 10, "R8", first_out - first_take, 10);
        // R11 / R2: every pair emitted, nothing left over
        chk(q_lo.size() == 0, "R11", q_lo.size(), 0);
        chk(n_pairs == 45 * M, "R2", n_pairs, 45 * M);
        done = 1'b1;
    end

    initial begin
        for (int w = 0; w < 20000 && !done; w++) @(posedge clk);
        if (!done) chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule